// File: doc/BRIEF.md
# Direction-Configurable I/O Cell Array with Isolation

This block is a row of digital I/O cells of the kind that sit in the I/O tiles of a small programmable fabric. It has `N_CELLS` cells, 144 by default. Each cell links one fabric-side signal pair to one pad-side signal pair. A single direction bit per cell chooses whether the cell carries data from the pad into the fabric (input mode) or from the fabric out to the pad (output mode). The gated path that is not in use is always held at logic 0. This keeps stale or random data from leaking in either direction.

The direction bits are flip-flops on their own configuration clock. They are chained into one shift register, with a serial input, a serial output and a shift enable. During bring-up a loader shifts in one bit per cell and then drops the shift enable. The array then holds that pattern.

A global active-low isolation input, `quiet_n`, overrides every direction bit and forces all cells into input mode. Outputs therefore stay undriven until the loader has finished and releases isolation. Reset also sets every direction bit to 1, so the array comes up in input mode even before isolation is released.

Top module: `iocell_array`

## Requirements
- R1: A direction bit of 1 selects input mode and a bit of 0 selects output mode for its cell, while `quiet_n` is 1.
- R2: While `quiet_n` is 0, every cell is in input mode whatever its direction bit holds.
- R3: In input mode, `fab_din[i]` equals `ext_din[i]` and `ext_dout[i]` is held at 0, whatever `fab_dout[i]` does.
- R4: In output mode, `ext_dout[i]` equals `fab_dout[i]` and `fab_din[i]` is held at 0, whatever `ext_din[i]` does.
- R5: `ext_oe[i]` is 1 exactly when cell i is in output mode.
- R6: An asynchronous reset (`cfg_rst_n` low) sets every direction bit to 1, and `cfg_sout` then reads 1.
- R7: On each rising `cfg_clk` edge with `cfg_shift_en` high, `cfg_sin` enters the bit of cell N_CELLS-1 and every bit moves one cell toward cell 0. `cfg_sout` shows the bit of cell 0. After N_CELLS shifts, the first bit shifted in sits in cell 0 and the last sits in cell N_CELLS-1.
- R8: While `cfg_shift_en` is low, the direction bits keep their values and `cfg_sin` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock for the direction chain |
| cfg_rst_n | input | 1 | Asynchronous active-low reset; sets all direction bits to 1 |
| cfg_shift_en | input | 1 | Shift the direction chain by one cell per edge |
| cfg_sin | input | 1 | Serial data into the cell N_CELLS-1 end of the chain |
| cfg_sout | output | 1 | Serial data out; the bit of cell 0 |
| quiet_n | input | 1 | Active-low isolation; low forces every cell to input mode |
| fab_dout | input | N_CELLS | Data from the fabric toward the pads |
| fab_din | output | N_CELLS | Data toward the fabric; 0 in output mode |
| ext_din | input | N_CELLS | Data arriving from the pad side |
| ext_dout | output | N_CELLS | Data toward the pad side; 0 in input mode |
| ext_oe | output | N_CELLS | Pad drive enable; 1 in output mode |

## Verification
The isolation override and the configuration shift can act in the same cycle. A loader may be moving a pattern full of output-mode zeros through the chain while `quiet_n` is still low. The bench provokes this case by shifting a mixed pattern with isolation held low. After every shift it checks that no enable or pad-side output is active, even though the chain contents change on every edge. After isolation is released, the bench checks the full enable, pad-data and fabric-data vectors against the pattern. That pattern can only be correct if the shifts under isolation were taken.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

    // Encoding of a cell's direction bit.
    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } dir_e;

    // Value a gated, inactive path is parked at.
    localparam logic PARK_LEVEL = 1'b0;

    // Effective direction of one cell given isolation and its stored bit.
    function automatic dir_e eff_dir(input logic quiet_n, input logic cfg_bit);
        return (!quiet_n || cfg_bit) ? DIR_IN : DIR_OUT;
    endfunction

endpackage

// File: rtl/iocell_cfg_chain.sv
module iocell_cfg_chain #(
    parameter int N_CELLS = 144
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               sin,
    output logic [N_CELLS-1:0] dir_bits,
    output logic               sout
);
    localparam int TOP = N_CELLS - 1;

    typedef struct packed {
        logic [N_CELLS-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits      = st_q.bits >> 1;
            st_d.bits[TOP] = sin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bits: '1};
        else        st_q <= st_d;
    end

    assign dir_bits = st_q.bits;
    assign sout     = st_q.bits[0];

    // R7: a shift moves the serial input into the top cell, the rest down one
    p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (dir_bits[TOP] == $past(sin)) &&
                     ((dir_bits << 1) == ($past(dir_bits) & ~(N_CELLS'(1)))));

    // R8: without shift enable the chain holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(dir_bits));

endmodule

// File: rtl/iocell_cell.sv
module iocell_cell
    import iocell_pkg::*;
(
    input  logic quiet_n,
    input  logic cfg_bit,
    input  logic fab_dout,
    input  logic ext_din,
    output logic fab_din,
    output logic ext_dout,
    output logic ext_oe
);
    typedef struct packed {
        logic to_fab;
        logic to_ext;
        logic oe;
    } cell_out_t;

    cell_out_t out_d;
    dir_e      mode;

    always_comb begin
        mode       = eff_dir(quiet_n, cfg_bit);
        out_d      = '{to_fab: PARK_LEVEL, to_ext: PARK_LEVEL, oe: 1'b0};
        unique case (mode)
            DIR_IN:  out_d.to_fab = ext_din;
            DIR_OUT: begin
                out_d.to_ext = fab_dout;
                out_d.oe     = 1'b1;
            end
            default: out_d = '{to_fab: PARK_LEVEL, to_ext: PARK_LEVEL, oe: 1'b0};
        endcase
    end

    assign fab_din  = out_d.to_fab;
    assign ext_dout = out_d.to_ext;
    assign ext_oe   = out_d.oe;

endmodule

// File: rtl/iocell_array.sv
module iocell_array #(
    parameter int N_CELLS = 144
) (
    input  logic               cfg_clk,
    input  logic               cfg_rst_n,
    input  logic               cfg_shift_en,
    input  logic               cfg_sin,
    output logic               cfg_sout,
    input  logic               quiet_n,
    input  logic [N_CELLS-1:0] fab_dout,
    output logic [N_CELLS-1:0] fab_din,
    input  logic [N_CELLS-1:0] ext_din,
    output logic [N_CELLS-1:0] ext_dout,
    output logic [N_CELLS-1:0] ext_oe
);
    logic [N_CELLS-1:0] dir_bits;

    iocell_cfg_chain #(.N_CELLS(N_CELLS)) chain_i (
        .clk      (cfg_clk),
        .rst_n    (cfg_rst_n),
        .shift_en (cfg_shift_en),
        .sin      (cfg_sin),
        .dir_bits (dir_bits),
        .sout     (cfg_sout)
    );

    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        iocell_cell cell_i (
            .quiet_n  (quiet_n),
            .cfg_bit  (dir_bits[g]),
            .fab_dout (fab_dout[g]),
            .ext_din  (ext_din[g]),
            .fab_din  (fab_din[g]),
            .ext_dout (ext_dout[g]),
            .ext_oe   (ext_oe[g])
        );
    end

    // R2: isolation leaves no cell driving
    p_iso_input_r2: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        !quiet_n |-> (ext_oe == '0) && (ext_dout == '0));

    // R3: pad-side output is parked wherever the drive is off
    p_in_clean_r3: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        (ext_dout & ~ext_oe) == '0);

    // R4: fabric-side input is parked wherever the drive is on
    p_out_clean_r4: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        (fab_din & ext_oe) == '0);

    // R5: a drive enable only where the stored bit selects output
    p_oe_cfg_r5: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        (ext_oe & dir_bits) == '0);

endmodule

// File: tb/iocell_array_tb_top.sv
module iocell_array_tb_top;
    localparam int N = 144;

    logic         clk = 1'b0;
    logic         rst_n, shift_en, sin, sout, quiet_n;
    logic [N-1:0] fab_dout, fab_din, ext_din, ext_dout, ext_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    iocell_array #(.N_CELLS(N)) dut_i (
        .cfg_clk(clk), .cfg_rst_n(rst_n), .cfg_shift_en(shift_en), .cfg_sin(sin),
        .cfg_sout(sout), .quiet_n(quiet_n), .fab_dout(fab_dout), .fab_din(fab_din),
        .ext_din(ext_din), .ext_dout(ext_dout), .ext_oe(ext_oe)
    );

    typedef struct packed {
        logic [N-1:0] pat;
        logic         qn;
        logic [N-1:0] fo;
        logic [N-1:0] pi;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{pat: {N{1'b0}},       qn: 1'b1, fo: {36{4'hA}}, pi: {36{4'h5}}},
        '{pat: {N{1'b1}},       qn: 1'b1, fo: {N{1'b1}},  pi: {36{4'hC}}},
        '{pat: {72{2'b10}},     qn: 1'b1, fo: {N{1'b1}},  pi: {N{1'b1}}},
        '{pat: {18{8'h0F}},     qn: 1'b1, fo: {36{4'h6}}, pi: {36{4'h9}}},
        '{pat: {72{2'b01}},     qn: 1'b0, fo: {N{1'b1}},  pi: {36{4'h3}}}
    };

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk);
        sin = b;
        shift_en = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [N-1:0] p);
        for (int i = 0; i < N; i++) shift_bit(p[i]);
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    task automatic expect_all(input string tag, input logic [N-1:0] p, input logic qn,
                              input logic [N-1:0] fo, input logic [N-1:0] pi);
        logic [N-1:0] inmode;
        inmode = qn ? p : {N{1'b1}};
        chk({tag, " R5 oe"}, ext_oe, ~inmode);
        chk({tag, " R4 ext_dout"}, ext_dout, fo & ~inmode);
        chk({tag, " R3 fab_din"}, fab_din, pi & inmode);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [N-1:0] snap;
        rst_n = 1'b0; shift_en = 1'b0; sin = 1'b0; quiet_n = 1'b1;
        fab_dout = {N{1'b1}}; ext_din = {36{4'hB}};
        repeat (3) @(negedge clk);
        // R6: reset leaves every cell in input mode even with isolation released
        #1;
        chk("R6 oe after reset", ext_oe, '0);
        chk("R6 sout after reset", {{(N-1){1'b0}}, sout}, {{(N-1){1'b0}}, 1'b1});
        chk("R6 R3 fab_din after reset", fab_din, {36{4'hB}});
        rst_n = 1'b1;

        // Table: R1, R3, R4, R5 under varied patterns; last row isolated (R2)
        for (int v = 0; v < NV; v++) begin
            quiet_n = 1'b0;
            load(VECS[v].pat);
            quiet_n = VECS[v].qn;
            fab_dout = VECS[v].fo;
            ext_din = VECS[v].pi;
            #1;
            expect_all($sformatf("R1 vec%0d", v), VECS[v].pat, VECS[v].qn,
                       VECS[v].fo, VECS[v].pi);
        end

        // R7: ordering. One bit marked at cell 0, another at the top cell
        snap = {1'b1, {(N-2){1'b0}}, 1'b1};
        quiet_n = 1'b1;
        load(snap);
        #1;
        chk("R7 pattern placement", ~ext_oe, snap);
        chk("R7 sout shows cell 0", {{(N-1){1'b0}}, sout}, {{(N-1){1'b0}}, 1'b1});
        shift_bit(1'b0);
        chk("R7 one more shift", ~ext_oe, {1'b0, snap[N-1:1]});
        chk("R7 sout after shift", {{(N-1){1'b0}}, sout}, '0);
        @(negedge clk); shift_en = 1'b0;

        // R8: sin toggling with shift disabled changes nothing
        snap = ext_oe;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); sin = k[0];
        end
        #1;
        chk("R8 hold with shift off", ext_oe, snap);

        // R2 combined with shifting: isolation low while chain loads zeros
        quiet_n = 1'b0;
        fab_dout = {N{1'b1}};
        for (int i = 0; i < N; i++) begin
            shift_bit(1'b0);
            if (ext_oe != '0 || ext_dout != '0) begin
                chk("R2 isolated during shift", ext_oe | ext_dout, '0);
                break;
            end
        end
        @(negedge clk); shift_en = 1'b0;
        chk("R2 isolated after load", ext_oe, '0);
        ext_din = {N{1'b1}};
        #1;
        chk("R2 R3 fab_din passes while isolated", fab_din, {N{1'b1}});
        quiet_n = 1'b1;
        #1;
        chk("R2 release R4 ext_dout", ext_dout, {N{1'b1}});
        chk("R2 release R4 fab_din parked", fab_din, '0);

        // R6: asynchronous reset mid-operation
        @(negedge clk); rst_n = 1'b0; #1;
        chk("R6 async reset", ext_oe, '0);
        @(negedge clk); rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule